// File: doc/BRIEF.md
# Flow-Control Frame Nibble Transmitter

This block carries flow-control frames across a narrow side link, from the processor that receives them from the switch fabric to its partner processor. Frame words arrive 16 bits at a time from an upstream receive FIFO through a valid/ready handshake. The block starts sending a frame as soon as its header word is present (cut-through). Each word goes out as four 4-bit transfers, most significant nibble first. A start-of-frame strobe marks the first nibble of every header, and an odd horizontal parity bit goes with every nibble. After the last word of a frame the block appends a 16-bit vertical parity word. That word is either a plain column XOR or a DIP-16 style code with rotation, depending on a configuration input.

The two link-level ready flags in the outgoing header are always cleared. When no frame can start, the link carries filler: an idle frame, then a dead slot, then an idle frame again, and so on. A backpressure input from the far receiver stops new frames from starting. A frame already on the wire always runs to its end.

Top module: `fcnib_tx`

## Requirements
- R1: Every 16-bit word is sent over four consecutive cycles on `tx_dat`, bits [15:12] first and bits [3:0] last, with no gap between the words of a frame when the source keeps up.
- R2: `tx_sof` is 1 only on the first nibble of each frame header (data or idle frame) and 0 on all other cycles.
- R3: `tx_par` makes the number of ones in `{tx_dat, tx_par}` odd on every cycle.
- R4: In the header (first word) of every transmitted data frame, bit 7 (data-ready flag) and bit 6 (control-ready flag) are sent as 0. All other header bits are sent as received.
- R5: Cut-through: the header starts on the link one cycle after it is accepted, before later words of the frame have been offered. `in_ready` is only high on the last nibble cycle of a word slot.
- R6: Directly after the last word of a frame (the one with `in_eof`=1), the 16-bit vertical parity word is sent, most significant nibble first. It is computed over every word of the frame, using the header with its ready flags already cleared.
- R7: With `cfg_dip16`=0, the vertical parity word is the bitwise XOR of all words of the frame.
- R8: With `cfg_dip16`=1, the vertical parity accumulator starts at 0. For each word in order it becomes rotate-left-by-one of (accumulator XOR word).
- R9: When no data frame starts at a slot boundary, filler is sent. Filler alternates between an idle frame and a dead slot. An idle frame is a header of 0x0000 with `tx_sof` on its first nibble, followed by a parity word of 0x0000. A dead slot is four zero nibbles with `tx_sof` low. The first filler after a data frame is an idle frame.
- R10: While `rx_bp` is 1 at a slot boundary, no new frame header is accepted (`in_ready` stays 0) and filler is sent. A frame already started completes normally.
- R11: While `rst_n` is 0, `tx_dat` is 0, `tx_sof` is 0 and `tx_par` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dip16 | input | 1 | Vertical parity select: 0 column XOR, 1 rotating DIP-16 code; change only between frames |
| in_valid | input | 1 | Upstream FIFO presents a word |
| in_ready | output | 1 | Word is taken on this clock edge when `in_valid` is also 1 |
| in_data | input | 16 | Frame word from the FIFO |
| in_sof | input | 1 | Word is a frame header |
| in_eof | input | 1 | Word is the last word of the frame |
| rx_bp | input | 1 | Backpressure from the far receiver |
| tx_dat | output | 4 | Link data nibble |
| tx_sof | output | 1 | Start-of-frame strobe |
| tx_par | output | 1 | Odd horizontal parity of `tx_dat` |

## Verification
A word taken at the clock edge that closes a slot shows its first nibble on the link in the very next cycle. The following three nibbles come one per cycle, and the parity word follows the last frame word with no idle cycle. The first filler header appears on the cycle right after the final parity nibble. Since a slot boundary can fall on any of four phases, the checks do not count cycles from the stimulus. They lock onto the falling edge on which a nonzero start-of-frame header appears, then read each later nibble on successive falling edges. The checks that `in_ready` stays low under backpressure, and the parity scan, sample once per cycle on the falling edge, away from the edge at which the registers change.

// File: rtl/fcnib_pkg.sv
package fcnib_pkg;

   // Content of the word slot currently on the link
   typedef enum logic [1:0] {
      SLOT_DEAD = 2'd0,
      SLOT_IDLE = 2'd1,
      SLOT_DATA = 2'd2,
      SLOT_VPAR = 2'd3
   } slot_kind_e;

endpackage

// File: rtl/fcnib_hpar.sv
module fcnib_hpar #(
   parameter int W   = 4,
   parameter bit ODD = 1'b1
) (
   input  logic [W-1:0] data,
   output logic         par
);

   if (W < 1) begin : g_bad_w
      $error("fcnib_hpar: W must be at least 1");
   end

   if (ODD) begin : g_odd
      assign par = ~(^data);
   end else begin : g_even
      assign par = ^data;
   end

endmodule

// File: rtl/fcnib_shifter.sv
module fcnib_shifter #(
   parameter int WORD_W = 16,
   parameter int NIB_W  = 4,
   localparam int NIBS  = WORD_W / NIB_W,
   localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic [NIB_W-1:0]  nib_out,
   output logic [IDX_W-1:0]  nib_idx,
   output logic              slot_end
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

   logic [WORD_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;

   if (NIBS < 2) begin : g_bad_ratio
      $error("fcnib_shifter: a word must hold at least two nibbles");
   end
   if ((WORD_W % NIB_W) != 0) begin : g_bad_split
      $error("fcnib_shifter: WORD_W must be a multiple of NIB_W");
   end

   // Reset parks the counter on the last nibble so the first edge
   // after reset is a slot boundary.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= LAST_IDX;
      end else if (load) begin
         sh_q  <= word_in;
         idx_q <= '0;
      end else begin
         sh_q  <= sh_q << NIB_W;
         idx_q <= idx_q + 1'b1;
      end
   end

   assign nib_out  = sh_q[WORD_W-1 -: NIB_W];
   assign nib_idx  = idx_q;
   assign slot_end = (idx_q == LAST_IDX);

   // R1
   shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !slot_end) |=> (nib_out == $past(sh_q[WORD_W-NIB_W-1 -: NIB_W])));

endmodule

// File: rtl/fcnib_vpar.sv
module fcnib_vpar #(
   parameter int W   = 16,
   parameter int ROT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic         first,
   input  logic         dip,
   input  logic [W-1:0] word_in,
   output logic [W-1:0] acc_q
);

   logic [W-1:0] base;
   logic [W-1:0] mix;
   logic [W-1:0] rot;
   logic [W-1:0] acc_d;

   if (ROT < 1 || ROT >= W) begin : g_bad_rot
      $error("fcnib_vpar: ROT must lie in 1..W-1");
   end

   assign base = first ? '0 : acc_q;
   assign mix  = base ^ word_in;

   if (ROT >= 1 && ROT < W) begin : g_rot
      assign rot = {mix[W-1-ROT:0], mix[W-1 -: ROT]};
   end else begin : g_norot
      assign rot = mix;
   end

   assign acc_d = dip ? rot : mix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (upd) begin
         acc_q <= acc_d;
      end
   end

   // R7
   xor_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && first && !dip) |=> (acc_q == $past(word_in)));

endmodule

// File: rtl/fcnib_tx.sv
module fcnib_tx #(
   parameter int WORD_W   = 16,
   parameter int NIB_W    = 4,
   parameter int CRDY_BIT = 6,
   parameter int DRDY_BIT = 7,
   parameter bit HPAR_ODD = 1'b1,
   parameter int DIP_ROT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dip16,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              rx_bp,
   output logic [NIB_W-1:0]  tx_dat,
   output logic              tx_sof,
   output logic              tx_par
);
   import fcnib_pkg::*;

   localparam int NIBS  = WORD_W / NIB_W;
   localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
   localparam logic [WORD_W-1:0] ONE      = WORD_W'(1);
   localparam logic [WORD_W-1:0] RDY_MASK = ~((ONE << CRDY_BIT) | (ONE << DRDY_BIT));

   if (CRDY_BIT >= WORD_W || DRDY_BIT >= WORD_W || CRDY_BIT == DRDY_BIT) begin : g_bad_rdy
      $error("fcnib_tx: ready flag positions must be distinct and inside the word");
   end

   slot_kind_e        kind_q, kind_d;
   logic              eof_q, eof_d;
   logic              gap_q, gap_d;
   logic              nidle_q, nidle_d;
   logic              sof_q, sof_d;

   logic [WORD_W-1:0] ld_word;
   logic [WORD_W-1:0] hdr_clean;
   logic [WORD_W-1:0] vp_acc;
   logic [WORD_W-1:0] vp_word;
   logic              vp_upd, vp_first;
   logic [IDX_W-1:0]  nib_idx;
   logic              slot_end;
   logic              need_more, at_bound, fire;

   // ---------------------------------------------------------------
   // Slot scheduling
   // ---------------------------------------------------------------
   assign need_more = ((kind_q == SLOT_DATA) && !eof_q) || gap_q;
   assign at_bound  = !need_more && ((kind_q == SLOT_DEAD) || (kind_q == SLOT_VPAR));
   assign in_ready  = slot_end && (need_more || (at_bound && in_sof && !rx_bp));
   assign fire      = in_ready && in_valid;
   assign hdr_clean = in_data & RDY_MASK;

   always_comb begin
      kind_d   = kind_q;
      eof_d    = eof_q;
      gap_d    = gap_q;
      nidle_d  = nidle_q;
      sof_d    = 1'b0;
      ld_word  = '0;
      vp_upd   = 1'b0;
      vp_first = 1'b0;
      vp_word  = '0;
      if (need_more) begin
         if (fire) begin
            ld_word = in_data;
            kind_d  = SLOT_DATA;
            eof_d   = in_eof;
            gap_d   = 1'b0;
            vp_upd  = 1'b1;
            vp_word = in_data;
         end else begin
            kind_d  = SLOT_DEAD;
            gap_d   = 1'b1;
         end
      end else if ((kind_q == SLOT_DATA) || (kind_q == SLOT_IDLE)) begin
         ld_word = vp_acc;
         kind_d  = SLOT_VPAR;
      end else if (fire) begin
         ld_word  = hdr_clean;
         kind_d   = SLOT_DATA;
         eof_d    = in_eof;
         sof_d    = 1'b1;
         vp_upd   = 1'b1;
         vp_first = 1'b1;
         vp_word  = hdr_clean;
         nidle_d  = 1'b1;
      end else if (nidle_q) begin
         kind_d   = SLOT_IDLE;
         eof_d    = 1'b1;
         sof_d    = 1'b1;
         vp_upd   = 1'b1;
         vp_first = 1'b1;
         nidle_d  = 1'b0;
      end else begin
         kind_d   = SLOT_DEAD;
         nidle_d  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= SLOT_DEAD;
         eof_q   <= 1'b1;
         gap_q   <= 1'b0;
         nidle_q <= 1'b1;
         sof_q   <= 1'b0;
      end else if (slot_end) begin
         kind_q  <= kind_d;
         eof_q   <= eof_d;
         gap_q   <= gap_d;
         nidle_q <= nidle_d;
         sof_q   <= sof_d;
      end
   end

   // ---------------------------------------------------------------
   // Datapath pieces
   // ---------------------------------------------------------------
   fcnib_shifter #(
      .WORD_W (WORD_W),
      .NIB_W  (NIB_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (slot_end),
      .word_in  (ld_word),
      .nib_out  (tx_dat),
      .nib_idx  (nib_idx),
      .slot_end (slot_end)
   );

   fcnib_vpar #(
      .W   (WORD_W),
      .ROT (DIP_ROT)
   ) u_vpar (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (slot_end && vp_upd),
      .first   (vp_first),
      .dip     (cfg_dip16),
      .word_in (vp_word),
      .acc_q   (vp_acc)
   );

   fcnib_hpar #(
      .W   (NIB_W),
      .ODD (HPAR_ODD)
   ) u_hpar (
      .data (tx_dat),
      .par  (tx_par)
   );

   assign tx_sof = sof_q && (nib_idx == '0);

   // ---------------------------------------------------------------
   // Checks
   // ---------------------------------------------------------------
   // R5
   ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (nib_idx == '0));

   // R2
   sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sof |=> !tx_sof);

   // R2
   hdr_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_sof && !need_more) |=> tx_sof);

   // R3
   hpar_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^{tx_dat, tx_par}) == HPAR_ODD);

   // R10
   bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bp && at_bound) |-> !in_ready);

endmodule

// File: tb/tb_fcnib_tx.sv
module tb_fcnib_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_dip16 = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        in_sof = 1'b0;
   logic        in_eof = 1'b0;
   logic        rx_bp = 1'b0;
   logic [3:0]  tx_dat;
   logic        tx_sof;
   logic        tx_par;

   int checks = 0;
   int errors = 0;
   int par_err = 0;
   int data_sof_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fcnib_tx dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_dip16 (cfg_dip16),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .rx_bp     (rx_bp),
      .tx_dat    (tx_dat),
      .tx_sof    (tx_sof),
      .tx_par    (tx_par)
   );

   // Stimulus table: {dip, word count, w0, w1, w2, w3}
   localparam int NVEC = 6;
   localparam logic [67:0] VEC [NVEC] = '{
      {1'b0, 3'd2, 16'hA5C3, 16'h1234, 16'h0000, 16'h0000},
      {1'b1, 3'd2, 16'hF0FF, 16'h8001, 16'h0000, 16'h0000},
      {1'b0, 3'd3, 16'h9FC0, 16'hFFFF, 16'h0001, 16'h0000},
      {1'b1, 3'd4, 16'h7E81, 16'hAAAA, 16'h5555, 16'hC3C3},
      {1'b1, 3'd1, 16'h4321, 16'h0000, 16'h0000, 16'h0000},
      {1'b0, 3'd4, 16'h10C0, 16'h0000, 16'hFFFF, 16'h0F0F}
   };

   always @(negedge clk) begin
      if (rst_n) begin
         if ((^{tx_dat, tx_par}) !== 1'b1) par_err++;
         if (tx_sof && tx_dat != 4'h0) data_sof_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] vp_model(input logic [15:0] w [4], input int n, input bit dip);
      logic [15:0] acc = '0;
      for (int i = 0; i < n; i++) begin
         logic [15:0] m;
         m   = acc ^ ((i == 0) ? (w[i] & 16'hFF3F) : w[i]);
         acc = dip ? {m[14:0], m[15]} : m;
      end
      return acc;
   endfunction

   task automatic send_word(input logic [15:0] w, input bit s, input bit e);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      in_sof   = s;
      in_eof   = e;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [15:0] w [4], input int n);
      for (int i = 0; i < n; i++) send_word(w[i], i == 0, i == n - 1);
   endtask

   task automatic expect_frame(input logic [15:0] w [4], input int n, input bit dip);
      logic [15:0] exp_w [5];
      logic [15:0] got_w [5];
      int waitc = 0;
      bit sof_ok = 1'b1;
      bit body_ok = 1'b1;
      int bad_i = 0;
      for (int i = 0; i < 5; i++) begin
         exp_w[i] = '0;
         got_w[i] = '0;
      end
      exp_w[0] = w[0] & 16'hFF3F;
      for (int i = 1; i < n; i++) exp_w[i] = w[i];
      exp_w[n] = vp_model(w, n, dip);
      do begin
         @(negedge clk);
         waitc++;
      end while (!(tx_sof && tx_dat != 4'h0) && waitc < 400);
      for (int k = 0; k < (n + 1) * 4; k++) begin
         if (k > 0) @(negedge clk);
         got_w[k / 4] = {got_w[k / 4][11:0], tx_dat};
         if (tx_sof != (k == 0)) sof_ok = 1'b0;
      end
      for (int i = n - 1; i >= 0; i--) begin
         if (got_w[i] != exp_w[i]) begin
            body_ok = 1'b0;
            bad_i = i;
         end
      end
      check(got_w[0][7:6] == 2'b00, "R4", "header ready flags", 32'(got_w[0]), 32'(exp_w[0]));
      check(body_ok, "R1", "frame words", 32'(got_w[bad_i]), 32'(exp_w[bad_i]));
      check(sof_ok, "R2", "sof placement", 32'(sof_ok), 32'(1));
      check(got_w[n] == exp_w[n], dip ? "R6,R8" : "R6,R7", "vertical parity",
            32'(got_w[n]), 32'(exp_w[n]));
      @(negedge clk);
      check(tx_sof && tx_dat == 4'h0, "R9", "idle header after frame",
            32'({tx_sof, tx_dat}), 32'h10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] w [4];
      int n;
      int cnt0;
      int rdy_hi;
      bit got;
      bit sof_ok;
      bit zero_ok;

      // R11 reset state
      repeat (3) @(negedge clk);
      check(tx_dat == 4'h0, "R11", "tx_dat in reset", 32'(tx_dat), 32'h0);
      check(tx_sof == 1'b0, "R11", "tx_sof in reset", 32'(tx_sof), 32'h0);
      check(tx_par == 1'b1, "R11", "tx_par in reset", 32'(tx_par), 32'h1);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 filler alternation with no traffic
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tx_sof && n < 50);
      sof_ok  = tx_sof && (tx_dat == 4'h0);
      zero_ok = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         if (k < 12) begin
            if (tx_sof) sof_ok = 1'b0;
            if (tx_dat != 4'h0) zero_ok = 1'b0;
         end else if (!tx_sof) begin
            sof_ok = 1'b0;
         end
      end
      check(sof_ok, "R9", "idle/dead sof spacing", 32'(sof_ok), 32'h1);
      check(zero_ok, "R9", "filler nibbles zero", 32'(zero_ok), 32'h1);

      // Table walk: R1 R2 R4 R6 R7 R8 R9
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         cfg_dip16 = VEC[v][67];
         n = int'(VEC[v][66:64]);
         w[0] = VEC[v][63:48];
         w[1] = VEC[v][47:32];
         w[2] = VEC[v][31:16];
         w[3] = VEC[v][15:0];
         fork
            send_frame(w, n);
            expect_frame(w, n, cfg_dip16);
         join
      end

      // R10 backpressure blocks a waiting header
      @(negedge clk);
      cfg_dip16 = 1'b0;
      rx_bp     = 1'b1;
      in_valid  = 1'b1;
      in_data   = 16'hB2FF;
      in_sof    = 1'b1;
      in_eof    = 1'b0;
      cnt0   = data_sof_cnt;
      rdy_hi = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         #1;
         if (in_ready) rdy_hi++;
      end
      check(rdy_hi == 0, "R10", "in_ready under backpressure", 32'(rdy_hi), 32'h0);
      check(data_sof_cnt == cnt0, "R10", "frames started under backpressure",
            32'(data_sof_cnt - cnt0), 32'h0);
      in_valid = 1'b0;
      rx_bp    = 1'b0;
      w[0] = 16'hB2FF; w[1] = 16'h0F0F; w[2] = 16'h0; w[3] = 16'h0;
      fork
         send_frame(w, 2);
         expect_frame(w, 2, 1'b0);
      join

      // R10 backpressure raised mid-frame lets the frame finish
      @(negedge clk);
      cfg_dip16 = 1'b1;
      w[0] = 16'hC0C0; w[1] = 16'h1357; w[2] = 16'h9BDF; w[3] = 16'h0;
      fork
         send_frame(w, 3);
         expect_frame(w, 3, 1'b1);
         begin
            n = 0;
            do begin
               @(negedge clk);
               n++;
            end while (!(tx_sof && tx_dat != 4'h0) && n < 400);
            rx_bp = 1'b1;
         end
      join
      rx_bp = 1'b0;

      // R5 cut-through: header leaves before the rest is offered
      @(negedge clk);
      cfg_dip16 = 1'b0;
      w[0] = 16'hE0C1; w[1] = 16'h2468; w[2] = 16'h0; w[3] = 16'h0;
      fork
         begin
            cnt0 = data_sof_cnt;
            send_word(w[0], 1'b1, 1'b0);
            got = 1'b0;
            #2;
            for (int k = 0; k < 12 && !got; k++) begin
               if (data_sof_cnt != cnt0) got = 1'b1;
               else begin
                  @(negedge clk);
                  #2;
               end
            end
            check(got, "R5", "header sent before tail offered", 32'(got), 32'h1);
            send_word(w[1], 1'b0, 1'b1);
         end
         expect_frame(w, 2, 1'b0);
      join

      // R3 parity on every cycle seen so far
      check(par_err == 0, "R3", "odd parity violations", 32'(par_err), 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule